// File: doc/BRIEF.md
# LIN-Capable Serial Break Transmitter

This block is an asynchronous serial transmitter that sends 8N1 characters and, on request, a break: a run of bit times with the line held low. A single mode input selects the break length. With the mode input clear the break is ten bit times long. With it set the break is thirteen bit times long, which is the synch break that opens a LIN frame.

In LIN master use, the mode input is set once and the prescaler is programmed once. Software issues a break request and then writes the synch byte, the data bytes and the checksum byte, all at the same bit rate. The bit rate never has to be changed to stretch the break.

One bit time is sixteen times the prescaler value, counted in system clocks. For example, a 24 MHz clock with a prescaler of 75 gives 20 kbit/s. The prescaler value and the mode input are captured when a transfer is accepted.

Top module: `lin_break_tx`

## Requirements
- R1: After reset, and whenever busy_o is low, tx_o is high, busy_o is low and done_o is low, except for the single done_o cycle described in R8.
- R2: A character occupies ten bit times on tx_o: first a low start bit, then data bits 0 to 7 (least significant first), then a high stop bit. Each bit lasts exactly 16 × P system clocks, where P is the captured prescaler.
- R3: A break accepted while lin_mode_i is 0 holds tx_o low for 10 bit times. It is followed by one high delimiter bit time before the transfer ends.
- R4: A break accepted while lin_mode_i is 1 holds tx_o low for 13 bit times. It is followed by one high delimiter bit time.
- R5: lin_mode_i has no effect on the shape or timing of a character.
- R6: A request (brk_req_i or wr_valid_i) is accepted only at a rising clock edge where busy_o is low. A request raised while busy_o is high is dropped. It does not alter the transfer in progress and it does not start a new one.
- R7: If brk_req_i and wr_valid_i are both high at an accepting edge, the break is sent and the byte is dropped.
- R8: busy_o goes high in the cycle after the accepting edge and stays high for exactly (number of bits) × 16 × P cycles. When busy_o falls, done_o is high for exactly one cycle.
- R9: presc_i and lin_mode_i are captured at acceptance. Changing either one during a transfer does not alter that transfer.
- R10: A captured prescaler of 0 behaves as 1, giving a 16-clock bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| presc_i | input | PRESC_W | Prescaler; bit time is 16 × presc_i clocks |
| lin_mode_i | input | 1 | 1 selects the 13-bit break, 0 the 10-bit break |
| brk_req_i | input | 1 | Request to send a break |
| wr_valid_i | input | 1 | Request to send the byte on wr_data_i |
| wr_data_i | input | DATA_W | Byte to send |
| tx_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when a transfer ends |

## Verification
The assertions take for granted that a request only needs to be seen at one accepting edge. They also assume the prescaler may change at any time, because only the captured copy governs the bit timer. The stimulus raises each request for a single cycle while busy_o is low. It deliberately fires extra requests and changes the prescaler and the mode input in the middle of transfers, so that the capture and dropping rules are exercised against a bench model that uses only the values present at acceptance. Prescalers are kept between 0 and 3 so that every bit-time boundary of every frame is compared cycle by cycle.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'd0,
    XF_CHAR = 2'd1,
    XF_BRK  = 2'd2
  } xfer_e;
endpackage

// File: rtl/lin_bit_timer.sv
module lin_bit_timer #(
  parameter int PRESC_W = 8,
  parameter int OVS     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               run_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               bit_end_o
);
  localparam int OVS_W = $clog2(OVS);
  localparam int CNT_W = PRESC_W + OVS_W;

  logic [PRESC_W-1:0] eff;
  logic [CNT_W-1:0]   limit_new, limit_q, cnt_q;

  always_comb begin
    eff       = (presc_i == '0) ? PRESC_W'(1) : presc_i;
    limit_new = CNT_W'(eff) * CNT_W'(OVS) - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= CNT_W'(OVS - 1);
      cnt_q   <= '0;
    end else if (start_i) begin
      limit_q <= limit_new;
      cnt_q   <= limit_new;
    end else if (run_i) begin
      cnt_q <= (cnt_q == '0) ? limit_q : cnt_q - CNT_W'(1);
    end
  end

  assign bit_end_o = run_i && !start_i && (cnt_q == '0);

  assert_cnt_in_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit_q);
  assert_limit_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !start_i) |=> $stable(limit_q));
  assert_limit_floor_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_q >= CNT_W'(OVS - 1));
endmodule

// File: rtl/lin_tx_seq.sv
module lin_tx_seq
  import lin_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BRK_STD = 10,
  parameter int BRK_LIN = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lin_mode_i,
  input  logic              brk_req_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              bit_end_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              tx_o,
  output logic              done_o
);
  localparam int MAX_LAST = (BRK_LIN > DATA_W + 1) ? BRK_LIN : DATA_W + 1;
  localparam int IDX_W    = $clog2(MAX_LAST + 1);
  localparam logic [IDX_W-1:0] CHAR_LAST = IDX_W'(DATA_W + 1);

  xfer_e             kind_q;
  logic [IDX_W-1:0]  idx_q, last_q, idx_nxt;
  logic [DATA_W-1:0] shreg_q;
  logic              tx_q, done_q;

  assign busy_o  = (kind_q != XF_IDLE);
  assign start_o = !busy_o && (brk_req_i || wr_valid_i);
  assign idx_nxt = idx_q + IDX_W'(1);
  assign tx_o    = tx_q;
  assign done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= XF_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
      shreg_q <= '1;
      tx_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        tx_q  <= 1'b0;
        idx_q <= '0;
        if (brk_req_i) begin  // break wins a tie
          kind_q  <= XF_BRK;
          last_q  <= lin_mode_i ? IDX_W'(BRK_LIN) : IDX_W'(BRK_STD);
          shreg_q <= '1;
        end else begin
          kind_q  <= XF_CHAR;
          last_q  <= CHAR_LAST;
          shreg_q <= wr_data_i;
        end
      end else if (busy_o && bit_end_i) begin
        if (idx_q == last_q) begin
          kind_q <= XF_IDLE;
          tx_q   <= 1'b1;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_nxt;
          if (kind_q == XF_CHAR) begin
            tx_q    <= shreg_q[0];
            shreg_q <= {1'b1, shreg_q[DATA_W-1:1]};  // ones shift in to form stop bit
          end else begin
            tx_q <= (idx_nxt == last_q);  // delimiter after the low run
          end
        end
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
  assert_char_start_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && kind_q == XF_CHAR) |-> !tx_o);
  // covers R4 as well: low run length comes from last_q
  assert_brk_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_q == XF_BRK && idx_q < last_q) |-> !tx_o);
  assert_rise_on_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(brk_req_i || wr_valid_i));
  assert_fall_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/lin_break_tx.sv
module lin_break_tx #(
  parameter int PRESC_W = 8,
  parameter int DATA_W  = 8,
  parameter int OVS     = 16,
  parameter int BRK_STD = 10,
  parameter int BRK_LIN = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic               lin_mode_i,
  input  logic               brk_req_i,
  input  logic               wr_valid_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               tx_o,
  output logic               busy_o,
  output logic               done_o
);
  logic start, bit_end;

  lin_bit_timer #(.PRESC_W(PRESC_W), .OVS(OVS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (busy_o),
    .presc_i  (presc_i),
    .bit_end_o(bit_end)
  );

  lin_tx_seq #(.DATA_W(DATA_W), .BRK_STD(BRK_STD), .BRK_LIN(BRK_LIN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lin_mode_i(lin_mode_i),
    .brk_req_i (brk_req_i),
    .wr_valid_i(wr_valid_i),
    .wr_data_i (wr_data_i),
    .bit_end_i (bit_end),
    .start_o   (start),
    .busy_o    (busy_o),
    .tx_o      (tx_o),
    .done_o    (done_o)
  );
endmodule

// File: tb/tb_lin_break_tx.sv
module tb_lin_break_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] presc_i = 8'd1;
  logic       lin_mode_i = 1'b0;
  logic       brk_req_i = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       tx_o, busy_o, done_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  lin_break_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .presc_i(presc_i), .lin_mode_i(lin_mode_i),
    .brk_req_i(brk_req_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic bit exp_bit(bit brk, bit lin, logic [7:0] d, int idx);
    if (brk) return (idx < (lin ? 13 : 10)) ? 1'b0 : 1'b1;
    if (idx == 0) return 1'b0;
    if (idx <= 8) return d[idx-1];
    return 1'b1;
  endfunction

  function automatic int n_bits(bit brk, bit lin);
    return brk ? ((lin ? 13 : 10) + 1) : 10;
  endfunction

  // p_alt >= 0: change prescaler and flip mode mid-transfer; poke > 0: extra requests at that cycle
  task automatic run_xfer(bit brk, bit lin, logic [7:0] d, int p, int p_alt,
                          int poke, bit both, string tag);
    int  per, tot, bad, bad_act, bad_exp;
    bit  kb, e;
    kb  = brk || both;
    per = 16 * ((p == 0) ? 1 : p);
    tot = n_bits(kb, lin) * per;
    bad = -1; bad_act = 0; bad_exp = 0;
    @(negedge clk);
    presc_i = 8'(p); lin_mode_i = lin; wr_data_i = d;
    brk_req_i = kb; wr_valid_i = !brk || both;
    @(negedge clk);
    brk_req_i = 1'b0; wr_valid_i = 1'b0;
    for (int c = 0; c < tot; c++) begin
      if (c > 0) @(negedge clk);
      e = exp_bit(kb, lin, d, c / per);
      if (bad < 0 && (tx_o !== e || busy_o !== 1'b1)) begin
        bad = c; bad_act = {busy_o, tx_o}; bad_exp = {1'b1, e};
      end
      if (c == 2 && p_alt >= 0) begin presc_i = 8'(p_alt); lin_mode_i = !lin; end
      if (poke > 0 && c == poke) begin brk_req_i = 1'b1; wr_valid_i = 1'b1; wr_data_i = ~d; end
      if (poke > 0 && c == poke + 1) begin brk_req_i = 1'b0; wr_valid_i = 1'b0; end
    end
    chk(bad < 0, tag, $sformatf("{busy,tx} at cycle %0d", bad), bad_act, bad_exp);
    @(negedge clk);
    chk(busy_o == 0 && done_o == 1 && tx_o == 1, "R8", "{busy,done,tx} at end",
        {busy_o, done_o, tx_o}, 3'b011);
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && tx_o == 1, "R6", "{busy,done,tx} after end",
        {busy_o, done_o, tx_o}, 3'b001);
  endtask

  initial begin
    bit rb, rl;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_o == 1 && busy_o == 0 && done_o == 0, "R1", "{tx,busy,done} after reset",
        {tx_o, busy_o, done_o}, 3'b100);

    run_xfer(0, 0, 8'h55, 1, -1, 0, 0, "R2");
    run_xfer(0, 1, 8'hA3, 2, -1, 0, 0, "R5");
    run_xfer(1, 0, 8'h00, 1, -1, 0, 0, "R3");
    run_xfer(1, 1, 8'h00, 1, -1, 0, 0, "R4");
    run_xfer(0, 0, 8'h0F, 0, -1, 0, 0, "R10");
    run_xfer(1, 1, 8'h00, 0, -1, 0, 0, "R10");
    run_xfer(0, 0, 8'hC6, 3, 1, 0, 0, "R9");
    run_xfer(1, 0, 8'h00, 2, 5, 0, 0, "R9");
    run_xfer(0, 1, 8'h81, 1, -1, 20, 0, "R6");
    run_xfer(1, 1, 8'h00, 1, -1, 50, 0, "R6");
    run_xfer(0, 0, 8'h3C, 1, -1, 0, 1, "R7");

    for (int i = 0; i < 10; i++) begin
      rb = 1'($urandom_range(0, 1));
      rl = 1'($urandom_range(0, 1));
      run_xfer(rb, rl, 8'($urandom_range(0, 255)), int'($urandom_range(0, 3)),
               -1, 0, 0, rb ? (rl ? "R4" : "R3") : "R2");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule